// File: doc/BRIEF.md
# Shared-Window GPIO Bank Array

This block holds the register state for several banks of 32 general-purpose I/O lines. Every line owns a configuration word: function code, direction, pull selection, input filter bits, open-drain, Schmitt control, drive strength and event selection. Software does not see one register per line. Each bank has a single configuration window and a line-select mask register in front of it. A write to the window lands on every line whose mask bit is set. A read of the window returns the word of one selected line.

Each bank also holds an output latch, which software changes through separate set and clear registers. A read-back register shows the latch. A second read-back register shows the pad levels after a two-stage synchronizer. Banks sit 0x40 bytes apart. Address space for banks beyond the configured count reads as zero and ignores writes.

The per-line outputs go to the pad ring and to an external pin multiplexer: output value, output enable, function code, pull-up, pull-down, open-drain, Schmitt and drive strength.

Top module: `gpio_mask_bank`

## Requirements
- R1: After reset, every configuration word, every mask register and the output latch are zero, so all pad outputs read 0.
- R2: Offset 0x00 of a bank is its line-select mask: it is written with the full 32-bit data and reads back that value.
- R3: A write to offset 0x04 updates the configuration word of every line whose mask bit is 1, and it leaves lines with a 0 mask bit untouched.
- R4: A read of offset 0x04 returns the word of the lowest-numbered line selected in the mask, or 0 when the mask is zero. Only the defined fields are stored: function [2:0], direction bit 8, pull-up bit 9, pull-down bit 10, filter enable bit 12, slow filter select bit 13, open-drain bit 14, Schmitt bit 15, drive [17:16] and event select [26:24]. Every other bit reads 0.
- R5: A write to offset 0x10 sets the output latch of each line whose data bit is 1. Lines with a 0 data bit keep their value.
- R6: A write to offset 0x14 clears the output latch of each line whose data bit is 1. Lines with a 0 data bit keep their value.
- R7: Offset 0x18 reads the output latch of the bank, and the latch drives the pad output value.
- R8: Offset 0x08 reads the pad inputs through two flops: a level applied before rising edge k appears after edge k+1.
- R9: Offset 0x0C, the lock status, always reads 0, and writes to it have no effect.
- R10: Per line, output enable equals the direction bit, and the function code (0 = GPIO, 1 to 7 = peripheral A to G), drive strength, open-drain and Schmitt outputs equal their configuration fields.
- R11: When both pull bits are set, pull-up is driven and pull-down is forced low. Otherwise each pull output follows its own bit.
- R12: Bank b occupies addresses b*0x40 to b*0x40+0x3F, and banks are independent. Bank numbers at or above NUM_BANKS read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write enable for the current address |
| bus_addr | input | ADDR_W | Byte address: bank in the upper bits, register offset in [5:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | NUM_BANKS*32 | Raw pad levels, line n of bank b at b*32+n |
| pad_out | output | NUM_BANKS*32 | Output latch value per line |
| pad_oe | output | NUM_BANKS*32 | Output enable per line |
| pad_func | output | NUM_BANKS*96 | 3-bit function code per line |
| pad_pu | output | NUM_BANKS*32 | Pull-up enable per line |
| pad_pd | output | NUM_BANKS*32 | Pull-down enable per line, after pull-up priority |
| pad_od | output | NUM_BANKS*32 | Open-drain per line |
| pad_schmitt | output | NUM_BANKS*32 | Schmitt control per line |
| pad_drv | output | NUM_BANKS*64 | 2-bit drive strength per line |

## Verification
The bench targets reads with several mask bits set, where the lowest selected line must win. A design that scanned from the top would return the word of the highest line. It also checks a read with an empty mask, and writes that carry only undefined bits, which would reveal storage of bits outside the fields. Set and clear writes with zero data must leave the latch alone; a design that wrote the data straight into the latch would wipe it. The pad read-back is sampled one and two edges after a pin change to catch a synchronizer with the wrong depth. Writes to a missing bank and to the lock offset are followed by reads of the neighbouring registers to show that nothing leaked across.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int LINES   = 32;
  localparam int LINE_IW = $clog2(LINES);
  localparam int OFS_W   = 6;

  localparam logic [OFS_W-1:0] OFS_MASK = 6'h00;
  localparam logic [OFS_W-1:0] OFS_CFG  = 6'h04;
  localparam logic [OFS_W-1:0] OFS_PINS = 6'h08;
  localparam logic [OFS_W-1:0] OFS_LOCK = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_SET  = 6'h10;
  localparam logic [OFS_W-1:0] OFS_CLR  = 6'h14;
  localparam logic [OFS_W-1:0] OFS_OUT  = 6'h18;

  typedef struct packed {
    logic [2:0] evt;
    logic [1:0] drv;
    logic       schmitt;
    logic       od;
    logic       filt_slow;
    logic       filt_en;
    logic       pd;
    logic       pu;
    logic       dir;
    logic [2:0] func;
  } line_cfg_t;

  function automatic line_cfg_t cfg_from_word(input logic [31:0] w);
    line_cfg_t c;
    c.func      = w[2:0];
    c.dir       = w[8];
    c.pu        = w[9];
    c.pd        = w[10];
    c.filt_en   = w[12];
    c.filt_slow = w[13];
    c.od        = w[14];
    c.schmitt   = w[15];
    c.drv       = w[17:16];
    c.evt       = w[26:24];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(input line_cfg_t c);
    logic [31:0] w;
    w         = '0;
    w[2:0]    = c.func;
    w[8]      = c.dir;
    w[9]      = c.pu;
    w[10]     = c.pd;
    w[12]     = c.filt_en;
    w[13]     = c.filt_slow;
    w[14]     = c.od;
    w[15]     = c.schmitt;
    w[17:16]  = c.drv;
    w[26:24]  = c.evt;
    return w;
  endfunction

  // Index of the lowest set bit; 0 when none is set.
  function automatic logic [LINE_IW-1:0] first_set(input logic [LINES-1:0] m);
    logic [LINE_IW-1:0] idx;
    idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (m[i]) idx = LINE_IW'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/gpb_line_cfg.sv
module gpb_line_cfg
  import gpb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  line_cfg_t wcfg,
  output line_cfg_t cfg_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_o <= '0;
    else if (we) cfg_o <= wcfg;
  end
endmodule

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
  import gpb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel,
  input  logic                  wr_en,
  input  logic [OFS_W-1:0]      ofs,
  input  logic [31:0]           wdata,
  input  logic [LINES-1:0]      pin_i,
  output logic [31:0]           rdata,
  output logic [LINES-1:0]      out_o,
  output line_cfg_t [LINES-1:0] cfgs_o,
  output logic [LINES-1:0]      cfg_we_o,
  output logic [LINES-1:0]      set_o,
  output logic [LINES-1:0]      clr_o,
  output logic [LINES-1:0]      pins_o
);
  logic             wr;
  logic [LINES-1:0] mask_q;
  line_cfg_t        wcfg;

  assign wr       = sel && wr_en;
  assign wcfg     = cfg_from_word(wdata);
  assign cfg_we_o = (wr && ofs == OFS_CFG) ? mask_q : '0;
  assign set_o    = (wr && ofs == OFS_SET) ? wdata  : '0;
  assign clr_o    = (wr && ofs == OFS_CLR) ? wdata  : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       mask_q <= '0;
    else if (wr && ofs == OFS_MASK)   mask_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_o <= '0;
    else        out_o <= (out_o | set_o) & ~clr_o;
  end

  for (genvar l = 0; l < LINES; l++) begin : g_line
    gpb_line_cfg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we_o[l]),
      .wcfg  (wcfg),
      .cfg_o (cfgs_o[l])
    );
  end

  gpb_sync #(.W(LINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_i),
    .q     (pins_o)
  );

  always_comb begin
    rdata = '0;
    unique case (ofs)
      OFS_MASK: rdata = mask_q;
      OFS_CFG:  rdata = (|mask_q) ? cfg_to_word(cfgs_o[first_set(mask_q)]) : '0;
      OFS_PINS: rdata = pins_o;
      OFS_OUT:  rdata = out_o;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
  import gpb_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [NUM_BANKS*LINES-1:0] pad_in,
  output logic [NUM_BANKS*LINES-1:0] pad_out,
  output logic [NUM_BANKS*LINES-1:0] pad_oe,
  output logic [NUM_BANKS*LINES*3-1:0] pad_func,
  output logic [NUM_BANKS*LINES-1:0] pad_pu,
  output logic [NUM_BANKS*LINES-1:0] pad_pd,
  output logic [NUM_BANKS*LINES-1:0] pad_od,
  output logic [NUM_BANKS*LINES-1:0] pad_schmitt,
  output logic [NUM_BANKS*LINES*2-1:0] pad_drv
);
  localparam int NL      = NUM_BANKS * LINES;
  localparam int BANK_IW = ADDR_W - OFS_W;

  logic [BANK_IW-1:0] bank_idx;
  logic [OFS_W-1:0]   ofs;
  logic [NUM_BANKS-1:0] bank_sel;
  logic [31:0]        bank_rd [NUM_BANKS];

  line_cfg_t [NL-1:0] cfg_all;
  logic [NL-1:0]      cfg_we_all;
  logic [NL-1:0]      set_all;
  logic [NL-1:0]      clr_all;
  logic [NL-1:0]      pins_sync_all;
  logic               lock_rd;

  assign bank_idx = bus_addr[ADDR_W-1:OFS_W];
  assign ofs      = bus_addr[OFS_W-1:0];
  assign lock_rd  = (ofs == OFS_LOCK);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_sel[b] = (bank_idx == BANK_IW'(b));

    gpb_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (bank_sel[b]),
      .wr_en    (bus_we),
      .ofs      (ofs),
      .wdata    (bus_wdata),
      .pin_i    (pad_in[b*LINES +: LINES]),
      .rdata    (bank_rd[b]),
      .out_o    (pad_out[b*LINES +: LINES]),
      .cfgs_o   (cfg_all[b*LINES +: LINES]),
      .cfg_we_o (cfg_we_all[b*LINES +: LINES]),
      .set_o    (set_all[b*LINES +: LINES]),
      .clr_o    (clr_all[b*LINES +: LINES]),
      .pins_o   (pins_sync_all[b*LINES +: LINES])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel[b]) bus_rdata = bus_rdata | bank_rd[b];
    end
  end

  for (genvar n = 0; n < NL; n++) begin : g_pad
    assign pad_oe[n]          = cfg_all[n].dir;
    assign pad_func[n*3 +: 3] = cfg_all[n].func;
    assign pad_pu[n]          = cfg_all[n].pu;
    assign pad_pd[n]          = cfg_all[n].pd & ~cfg_all[n].pu;
    assign pad_od[n]          = cfg_all[n].od;
    assign pad_schmitt[n]     = cfg_all[n].schmitt;
    assign pad_drv[n*2 +: 2]  = cfg_all[n].drv;
  end
endmodule

// File: rtl/gpb_chk.sv
module gpb_chk #(
  parameter int NL = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NL-1:0] pad_in,
  input logic [NL-1:0] pad_out,
  input logic [NL-1:0] pad_oe,
  input logic [NL-1:0] pad_pu,
  input logic [NL-1:0] pad_pd,
  input logic [NL-1:0] cfg_we_all,
  input logic [NL-1:0] set_all,
  input logic [NL-1:0] clr_all,
  input logic [NL-1:0] pins_sync_all,
  input logic          lock_rd,
  input logic [31:0]   bus_rdata
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  assert_unselected_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ $past(pad_oe)) & ~$past(cfg_we_all)) == '0);

  assert_set_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_all) |=> ((pad_out & $past(set_all)) == $past(set_all)));

  assert_clear_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_all) |=> ((~pad_out & $past(clr_all)) == $past(clr_all)));

  assert_two_flop_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (pins_sync_all == $past(pad_in, 2)));

  assert_lock_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_rd |-> (bus_rdata == 32'h0));

  assert_pull_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);
endmodule

bind gpio_mask_bank gpb_chk #(.NL(NL)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pad_in        (pad_in),
  .pad_out       (pad_out),
  .pad_oe        (pad_oe),
  .pad_pu        (pad_pu),
  .pad_pd        (pad_pd),
  .cfg_we_all    (cfg_we_all),
  .set_all       (set_all),
  .clr_all       (clr_all),
  .pins_sync_all (pins_sync_all),
  .lock_rd       (lock_rd),
  .bus_rdata     (bus_rdata)
);

// File: tb/gpio_mask_bank_bench.sv
`timescale 1ns/1ps
module gpio_mask_bank_bench;
  localparam int NB = 4;
  localparam int NL = NB * 32;
  localparam logic [31:0] KEEP = 32'h0703_F707;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NL-1:0] pad_in = '0;
  logic [NL-1:0] pad_out, pad_oe, pad_pu, pad_pd, pad_od, pad_schmitt;
  logic [NL*3-1:0] pad_func;
  logic [NL*2-1:0] pad_drv;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_mask_bank #(.NUM_BANKS(NB), .ADDR_W(10)) u_gpio_mask_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_func(pad_func), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .pad_od(pad_od), .pad_schmitt(pad_schmitt), .pad_drv(pad_drv)
  );

  // Reference model
  logic [31:0] m_cfg [NL];
  logic [31:0] m_mask [NB];
  logic [NL-1:0] m_out, m_p1, m_p2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) m_cfg[i] = '0;
      for (int i = 0; i < NB; i++) m_mask[i] = '0;
      m_out = '0; m_p1 = '0; m_p2 = '0;
    end else begin
      m_p2 = m_p1;
      m_p1 = pad_in;
      if (bus_we) begin
        int b;
        b = int'(bus_addr) / 64;
        if (b < NB) begin
          case (int'(bus_addr) % 64)
            'h00: m_mask[b] = bus_wdata;
            'h04: for (int l = 0; l < 32; l++)
                    if (m_mask[b][l]) m_cfg[b*32+l] = bus_wdata & KEEP;
            'h10: for (int l = 0; l < 32; l++)
                    if (bus_wdata[l]) m_out[b*32+l] = 1'b1;
            'h14: for (int l = 0; l < 32; l++)
                    if (bus_wdata[l]) m_out[b*32+l] = 1'b0;
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [31:0] exp_read(input logic [9:0] a);
    int b, o;
    b = int'(a) / 64;
    o = int'(a) % 64;
    if (b >= NB) return 32'h0;
    case (o)
      'h00: return m_mask[b];
      'h04: begin
        for (int l = 0; l < 32; l++) if (m_mask[b][l]) return m_cfg[b*32+l];
        return 32'h0;
      end
      'h08: return m_p2[b*32 +: 32];
      'h18: return m_out[b*32 +: 32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(input logic [9:0] a);
    if (int'(a) / 64 >= NB) return "R12";
    case (int'(a) % 64)
      'h00: return "R2";
      'h04: return "R4";
      'h08: return "R8";
      'h0C: return "R9";
      'h18: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [NL*3-1:0] act, input logic [NL*3-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic [NL-1:0] e_oe, e_pu, e_pd, e_od, e_sm;
      logic [NL*3-1:0] e_fn;
      logic [NL*2-1:0] e_dr;
      for (int n = 0; n < NL; n++) begin
        e_oe[n] = m_cfg[n][8];
        e_pu[n] = m_cfg[n][9];
        e_pd[n] = m_cfg[n][10] && !m_cfg[n][9];
        e_od[n] = m_cfg[n][14];
        e_sm[n] = m_cfg[n][15];
        e_fn[n*3 +: 3] = m_cfg[n][2:0];
        e_dr[n*2 +: 2] = m_cfg[n][17:16];
      end
      chk(read_tag(bus_addr), {{(NL*3-32){1'b0}}, bus_rdata}, {{(NL*3-32){1'b0}}, exp_read(bus_addr)});
      chk("R7 pad_out", {{(NL*2){1'b0}}, pad_out}, {{(NL*2){1'b0}}, m_out});
      chk("R10 oe", {{(NL*2){1'b0}}, pad_oe}, {{(NL*2){1'b0}}, e_oe});
      chk("R10 func", pad_func, e_fn);
      chk("R10 drv/od/schmitt", {{(NL*0){1'b0}}, pad_drv, pad_od, pad_schmitt},
          {e_dr, e_od, e_sm});
      chk("R11 pulls", {{(NL){1'b0}}, pad_pu, pad_pd}, {{(NL){1'b0}}, e_pu, e_pd});
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 10'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 10'(a);
    @(posedge clk); #2;
    chk(tag, {{(NL*3-32){1'b0}}, bus_rdata}, {{(NL*3-32){1'b0}}, e});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd('h000, 32'h0, "R1 mask");
    rd('h004, 32'h0, "R1 cfg");
    rd('h018, 32'h0, "R1 latch");
    chk("R1 pads", {{(NL*2){1'b0}}, pad_out | pad_oe | pad_pu | pad_pd}, '0);

    // R2: mask registers per bank
    wr('h000, 32'h0000_00F0);
    wr('h080, 32'h8000_0001);
    rd('h000, 32'h0000_00F0, "R2 bank0");
    rd('h080, 32'h8000_0001, "R2 bank2");

    // R3: write lands on all selected lines only
    wr('h004, 32'hFFFF_FFFF);
    wr('h000, 32'h0000_0008);
    rd('h004, 32'h0, "R3 unselected line 3");
    wr('h000, 32'h0000_0020);
    rd('h004, KEEP, "R3 selected line 5");
    wr('h000, 32'h0000_0100);
    rd('h004, 32'h0, "R3 unselected line 8");

    // R4: lowest selected line wins; empty mask; undefined bits
    wr('h000, 32'h0000_0080);
    wr('h004, 32'h0000_0105);
    wr('h000, 32'h0000_00C0);
    rd('h004, KEEP, "R4 lowest of two");
    wr('h000, 32'h0000_0000);
    rd('h004, 32'h0, "R4 empty mask");
    wr('h000, 32'h0000_0200);
    wr('h004, 32'hF8F8_08F8);
    rd('h004, 32'h0, "R4 undefined bits dropped");

    // R5/R6/R7: set and clear ports
    wr('h050, 32'h0000_00FF);
    rd('h058, 32'h0000_00FF, "R5 set");
    wr('h050, 32'h0000_0000);
    rd('h058, 32'h0000_00FF, "R5 zero set no effect");
    wr('h054, 32'h0000_000F);
    rd('h058, 32'h0000_00F0, "R6 clear");
    wr('h054, 32'h0000_0000);
    rd('h058, 32'h0000_00F0, "R6 zero clear no effect");
    chk("R7 latch on pads", {{(NL*3-32){1'b0}}, pad_out[63:32]}, {{(NL*3-32){1'b0}}, 32'h0000_00F0});

    // R8: two-flop pin path
    @(negedge clk);
    bus_addr = 10'h008;
    pad_in[31:0] = 32'hA5A5_0001;
    @(posedge clk); #2;
    chk("R8 after one edge", {{(NL*3-32){1'b0}}, bus_rdata}, '0);
    @(posedge clk); #2;
    chk("R8 after two edges", {{(NL*3-32){1'b0}}, bus_rdata}, {{(NL*3-32){1'b0}}, 32'hA5A5_0001});

    // R9: lock status
    wr('h0CC, 32'hFFFF_FFFF);
    rd('h0CC, 32'h0, "R9 lock reads zero");
    rd('h0C0, 32'h0, "R9 lock write leaves mask");

    // R10: per-line exports, bank 3 line 0
    wr('h0C0, 32'h0000_0001);
    wr('h0C4, 32'h0002_C103);
    chk("R10 oe", {{(NL*3-1){1'b0}}, pad_oe[96]}, {{(NL*3-1){1'b0}}, 1'b1});
    chk("R10 func", {{(NL*3-3){1'b0}}, pad_func[288 +: 3]}, {{(NL*3-3){1'b0}}, 3'd3});
    chk("R10 drive", {{(NL*3-4){1'b0}}, pad_drv[192 +: 2], pad_od[96], pad_schmitt[96]},
        {{(NL*3-4){1'b0}}, 2'd2, 1'b1, 1'b1});

    // R11: pull priority, bank 3 line 0
    wr('h0C4, 32'h0000_0600);
    chk("R11 both set", {{(NL*3-2){1'b0}}, pad_pu[96], pad_pd[96]}, {{(NL*3-2){1'b0}}, 2'b10});
    wr('h0C4, 32'h0000_0400);
    chk("R11 pd only", {{(NL*3-2){1'b0}}, pad_pu[96], pad_pd[96]}, {{(NL*3-2){1'b0}}, 2'b01});

    // R12: bank stride and missing banks
    wr('h040, 32'h1234_5678);
    rd('h000, 32'h0000_0200, "R12 bank0 untouched by bank1");
    wr('h140, 32'hFFFF_FFFF);
    wr('h144, 32'hFFFF_FFFF);
    wr('h150, 32'hFFFF_FFFF);
    rd('h140, 32'h0, "R12 missing bank reads zero");
    rd('h040, 32'h1234_5678, "R12 bank1 mask kept");

    // Random traffic compared every cycle against the model
    for (int i = 0; i < 600; i++) begin
      int b, o;
      @(negedge clk);
      b = ($urandom % 8 == 0) ? 4 + int'($urandom % 12) : int'($urandom % NB);
      case ($urandom % 7)
        0: o = 'h00; 1: o = 'h04; 2: o = 'h08; 3: o = 'h0C;
        4: o = 'h10; 5: o = 'h14; default: o = 'h18;
      endcase
      bus_addr = 10'(b * 64 + o);
      bus_we = ($urandom % 2) == 1;
      bus_wdata = ($urandom % 3 == 0) ? (32'h1 << ($urandom % 32)) : $urandom;
      if ($urandom % 4 == 0) pad_in[($urandom % NB) * 32 +: 32] = $urandom;
    end
    @(negedge clk);
    bus_we = 1'b0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule